// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching one translation entry from a flat table held in physical memory. The table start comes from a base-register input. The upper 20 address bits select the entry. The low 12 bits pass through unchanged, so each page is 4096 bytes. The walker issues one read on a simple memory port. It waits for the data, then decodes the entry. It returns the physical page number, the rights held in the entry, and a fault code.

The fault code tells the requester what went wrong. A page fault means the mapping is absent. A protection fault means the mapping exists but the requested access is not allowed. The access type and the privilege of the requester are both inputs to the rights check. Only one walk is in flight at a time. A new request is taken only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high exactly while the walker is idle. A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. A `req_valid` held high, or changed, while a walk is in progress has no effect on that walk and starts no new one.
- R2: In the cycle after a request is taken, `mem_req_valid` is high for exactly one cycle. During that cycle `mem_req_addr` equals `ptbr + 4*VPN`, where VPN is `req_vaddr[31:12]` and `ptbr` is the value sampled when the request was taken.
- R3: The walker waits any number of cycles for `mem_resp_valid`. The entry is captured on the edge where `mem_resp_valid` is high. `rsp_valid` is high for exactly the next cycle, and the walker is idle in the cycle after that.
- R4: The entry layout is: bit 31 valid, bit 30 read, bit 29 write, bit 28 execute, bit 27 kernel-only, bits 19:0 physical page number. Bits 26:20 have no effect on any response field.
- R5: An entry with bit 31 clear gives `rsp_fault` = 1 (page fault), whatever its other bits, the access type or the mode. In this case `rsp_perm`, `rsp_ppn` and `rsp_paddr` are zero.
- R6: `req_acc` encodes the access type, and each type needs its own right in the entry:

  | `req_acc` | Access | Right needed |
  |---|---|---|
  | 0 | load | read |
  | 1 | store | write |
  | 2 | fetch | execute |
  | 3 | reserved | always denied |

  A valid entry lacking the needed right gives `rsp_fault` = 2 (protection fault).
- R7: With `req_user` = 1, a valid entry that has the kernel-only bit set gives `rsp_fault` = 2. With `req_user` = 0, the kernel-only bit is ignored.
- R8: A permitted access gives `rsp_fault` = 0. In this case `rsp_ppn` is the entry's page number, `rsp_paddr` = {page number, `req_vaddr[11:0]`}, and `rsp_perm` = {read, write, execute}.
- R9: On a protection fault, `rsp_ppn` and `rsp_paddr` are zero, and `rsp_perm` still reports the entry's {read, write, execute} bits.
- R10: During and right after reset, the walker is idle: `req_ready` is high, and `mem_req_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| ptbr | input | 32 | Physical base address of the translation table |
| mem_req_valid | output | 1 | Entry read request, one-cycle pulse |
| mem_req_addr | output | 32 | Physical address of the entry |
| mem_resp_valid | input | 1 | Entry data present |
| mem_resp_data | input | 32 | Entry data |
| rsp_valid | output | 1 | Result present, one-cycle pulse |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| rsp_perm | output | 3 | Entry rights {read, write, execute} |
| rsp_ppn | output | 20 | Physical page number |
| rsp_paddr | output | 32 | Translated physical address |

## Verification
The properties assume that memory answers exactly once for each read request. They also assume that `mem_resp_valid` is never high except while the walker waits for that answer, since the checker reads the waiting phase from the outputs that are quiet in it. The bench memory model therefore raises one response pulse a chosen number of cycles after each request pulse, and never on its own. The stimulus also varies `req_vaddr` and `ptbr` during a walk, to show they are sampled only when a request is taken.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   // Walk sequencing
   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_READ = 2'd1,
      WS_WAIT = 2'd2,
      WS_DONE = 2'd3
   } walk_state_e;

   // Result classification
   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_PAGE = 2'd1,
      FLT_PROT = 2'd2
   } fault_e;

   // Requested access kind
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } access_e;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
   } rights_t;

endpackage

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
   import pt_walker_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        data_valid_i,
   output walk_state_e state_o
);

   walk_state_e state_q;
   walk_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         WS_IDLE: if (start_i)      state_d = WS_READ;
         WS_READ:                   state_d = WS_WAIT;
         WS_WAIT: if (data_valid_i) state_d = WS_DONE;
         WS_DONE:                   state_d = WS_IDLE;
         default:                   state_d = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= WS_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
   parameter int BASE_W      = 32,
   parameter int VPN_W       = 20,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [BASE_W-1:0] base_i,
   input  logic [VPN_W-1:0]  vpn_i,
   output logic [BASE_W-1:0] addr_o
);

   localparam int  SHIFT = $clog2(ENTRY_BYTES);
   localparam bit  POW2  = ((1 << SHIFT) == ENTRY_BYTES);

   if (ENTRY_BYTES < 1) begin : g_bad_size
      $error("pt_entry_addr: ENTRY_BYTES must be positive");
   end
   if (BASE_W < VPN_W) begin : g_bad_width
      $error("pt_entry_addr: BASE_W narrower than VPN_W");
   end

   logic [BASE_W-1:0] vpn_ext;
   assign vpn_ext = BASE_W'(vpn_i);

   if (POW2) begin : g_shift
      assign addr_o = base_i + (vpn_ext << SHIFT);
   end else begin : g_mult
      assign addr_o = base_i + vpn_ext * BASE_W'(ENTRY_BYTES);
   end

endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
   import pt_walker_pkg::*;
#(
   parameter int PTE_W         = 32,
   parameter int PPN_W         = 20,
   parameter bit WR_IMPLIES_RD = 1'b0
) (
   input  logic [PTE_W-1:0] pte_i,
   input  access_e          acc_i,
   input  logic             user_i,
   output fault_e           fault_o,
   output logic [PPN_W-1:0] ppn_o,
   output rights_t          rights_o
);

   localparam int V_POS = PTE_W - 1;
   localparam int R_POS = PTE_W - 2;
   localparam int W_POS = PTE_W - 3;
   localparam int X_POS = PTE_W - 4;
   localparam int K_POS = PTE_W - 5;

   if (PPN_W > K_POS) begin : g_bad_layout
      $error("pt_entry_check: page number overlaps flag bits");
   end

   rights_t rts;
   logic    load_ok;
   logic    allowed;
   fault_e  flt;
   logic    unused_pte;

   assign rts.rd = pte_i[R_POS];
   assign rts.wr = pte_i[W_POS];
   assign rts.ex = pte_i[X_POS];

   // Optional relaxation: a writable page may also be read
   if (WR_IMPLIES_RD) begin : g_rd_wide
      assign load_ok = rts.rd | rts.wr;
   end else begin : g_rd_strict
      assign load_ok = rts.rd;
   end

   always_comb begin
      unique case (acc_i)
         ACC_LOAD:  allowed = load_ok;
         ACC_STORE: allowed = rts.wr;
         ACC_FETCH: allowed = rts.ex;
         default:   allowed = 1'b0;
      endcase
   end

   // Missing mapping outranks any rights problem
   always_comb begin
      if (!pte_i[V_POS])                          flt = FLT_PAGE;
      else if (!allowed || (user_i && pte_i[K_POS])) flt = FLT_PROT;
      else                                        flt = FLT_NONE;
   end

   assign fault_o  = flt;
   assign ppn_o    = (flt == FLT_NONE) ? pte_i[PPN_W-1:0] : '0;
   assign rights_o = (flt == FLT_PAGE) ? '0 : rts;

   assign unused_pte = ^pte_i[K_POS-1:PPN_W];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int VA_W          = 32,
   parameter int OFS_W         = 12,
   parameter int PA_W          = 32,
   parameter int PTE_W         = 32,
   parameter int ENTRY_BYTES   = 4,
   parameter bit WR_IMPLIES_RD = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [VA_W-1:0]        req_vaddr,
   input  logic [1:0]             req_acc,
   input  logic                   req_user,
   input  logic [PA_W-1:0]        ptbr,
   output logic                   mem_req_valid,
   output logic [PA_W-1:0]        mem_req_addr,
   input  logic                   mem_resp_valid,
   input  logic [PTE_W-1:0]       mem_resp_data,
   output logic                   rsp_valid,
   output logic [1:0]             rsp_fault,
   output logic [2:0]             rsp_perm,
   output logic [PA_W-OFS_W-1:0]  rsp_ppn,
   output logic [PA_W-1:0]        rsp_paddr
);

   localparam int VPN_W = VA_W - OFS_W;
   localparam int PPN_W = PA_W - OFS_W;

   if (VA_W <= OFS_W) begin : g_bad_va
      $error("pt_walker: VA_W must exceed OFS_W");
   end
   if (PA_W <= OFS_W) begin : g_bad_pa
      $error("pt_walker: PA_W must exceed OFS_W");
   end

   walk_state_e       st;
   logic              accept;
   logic              take_data;
   logic [PA_W-1:0]   ent_addr_d;
   logic [PA_W-1:0]   ent_addr_q;
   logic [OFS_W-1:0]  off_q;
   access_e           acc_q;
   logic              user_q;
   logic [PTE_W-1:0]  pte_q;
   fault_e            flt;
   logic [PPN_W-1:0]  ppn;
   rights_t           rts;

   assign accept    = req_valid && (st == WS_IDLE);
   assign take_data = mem_resp_valid && (st == WS_WAIT);

   pt_entry_addr #(
      .BASE_W      (PA_W),
      .VPN_W       (VPN_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_addr (
      .base_i (ptbr),
      .vpn_i  (req_vaddr[VA_W-1:OFS_W]),
      .addr_o (ent_addr_d)
   );

   pt_walk_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (accept),
      .data_valid_i (take_data),
      .state_o      (st)
   );

   // Request context, frozen at acceptance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_addr_q <= '0;
         off_q      <= '0;
         acc_q      <= ACC_LOAD;
         user_q     <= 1'b0;
      end else if (accept) begin
         ent_addr_q <= ent_addr_d;
         off_q      <= req_vaddr[OFS_W-1:0];
         acc_q      <= access_e'(req_acc);
         user_q     <= req_user;
      end
   end

   // Fetched entry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pte_q <= '0;
      else if (take_data) pte_q <= mem_resp_data;
   end

   pt_entry_check #(
      .PTE_W         (PTE_W),
      .PPN_W         (PPN_W),
      .WR_IMPLIES_RD (WR_IMPLIES_RD)
   ) u_check (
      .pte_i    (pte_q),
      .acc_i    (acc_q),
      .user_i   (user_q),
      .fault_o  (flt),
      .ppn_o    (ppn),
      .rights_o (rts)
   );

   assign req_ready     = (st == WS_IDLE);
   assign mem_req_valid = (st == WS_READ);
   assign mem_req_addr  = ent_addr_q;
   assign rsp_valid     = (st == WS_DONE);
   assign rsp_fault     = flt;
   assign rsp_perm      = {rts.rd, rts.wr, rts.ex};
   assign rsp_ppn       = ppn;
   assign rsp_paddr     = (flt == FLT_NONE) ? {ppn, off_q} : '0;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int VA_W        = 32,
   parameter int OFS_W       = 12,
   parameter int PA_W        = 32,
   parameter int PTE_W       = 32,
   parameter int ENTRY_BYTES = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic [VA_W-1:0]       req_vaddr,
   input logic [1:0]            req_acc,
   input logic                  req_user,
   input logic [PA_W-1:0]       ptbr,
   input logic                  mem_req_valid,
   input logic [PA_W-1:0]       mem_req_addr,
   input logic                  mem_resp_valid,
   input logic [PTE_W-1:0]      mem_resp_data,
   input logic                  rsp_valid,
   input logic [1:0]            rsp_fault,
   input logic [2:0]            rsp_perm,
   input logic [PA_W-OFS_W-1:0] rsp_ppn,
   input logic [PA_W-1:0]       rsp_paddr
);

   logic waiting;
   logic unused_chk;

   // Waiting phase: no idle, no issue, no result on the outputs
   assign waiting    = !req_ready && !mem_req_valid && !rsp_valid;
   assign unused_chk = ^{req_acc, req_user, rsp_perm, rsp_ppn, rsp_paddr};

   p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_phase_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_ready, mem_req_valid, rsp_valid}));

   p_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> mem_req_valid);

   p_issue_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=>
         (mem_req_addr == $past(ptbr)
            + $past(PA_W'(req_vaddr[VA_W-1:OFS_W])) * PA_W'(ENTRY_BYTES)));

   p_issue_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);

   p_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && mem_resp_valid) |=> rsp_valid);

   p_result_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   p_page_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && mem_resp_valid && !mem_resp_data[PTE_W-1]) |=>
         (rsp_fault == 2'd1));

endmodule

bind pt_walker pt_walker_chk #(
   .VA_W        (VA_W),
   .OFS_W       (OFS_W),
   .PA_W        (PA_W),
   .PTE_W       (PTE_W),
   .ENTRY_BYTES (ENTRY_BYTES)
) u_chk (.*);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic        req_user = 1'b0;
   logic [31:0] ptbr = '0;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_resp_valid = 1'b0;
   logic [31:0] mem_resp_data = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_fault;
   logic [2:0]  rsp_perm;
   logic [19:0] rsp_ppn;
   logic [31:0] rsp_paddr;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   int lat   = 1;

   always #4 clk = ~clk;

   pt_walker u0 (.*);

   // Backing store for table entries
   logic [31:0] pt_mem [logic [31:0]];

   // Memory: one response pulse 'lat' cycles after each request pulse
   int          pend_cnt = 0;
   logic [31:0] pend_addr = '0;
   always @(negedge clk) begin
      mem_resp_valid <= 1'b0;
      if (pend_cnt > 0) begin
         pend_cnt = pend_cnt - 1;
         if (pend_cnt == 0) begin
            mem_resp_valid <= 1'b1;
            mem_resp_data  <= pt_mem.exists(pend_addr) ? pt_mem[pend_addr] : 32'h0;
         end
      end
      if (mem_req_valid) begin
         pend_addr = mem_req_addr;
         pend_cnt  = lat;
      end
   end

   // Behavioural reference: 0 idle, 1 issue, 2 wait, 3 result
   int          m_phase = 0;
   logic [31:0] m_addr = '0;
   logic [31:0] m_pte = '0;
   logic [11:0] m_off = '0;
   logic [1:0]  m_acc = '0;
   logic        m_user = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_phase <= 0;
      else begin
         case (m_phase)
            0: if (req_valid) begin
                  m_phase <= 1;
                  m_addr  <= ptbr + {10'h0, req_vaddr[31:12], 2'b00};
                  m_off   <= req_vaddr[11:0];
                  m_acc   <= req_acc;
                  m_user  <= req_user;
               end
            1: m_phase <= 2;
            2: if (mem_resp_valid) begin
                  m_phase <= 3;
                  m_pte   <= mem_resp_data;
               end
            default: m_phase <= 0;
         endcase
      end
   end

   function automatic int exp_fault(logic [31:0] e, logic [1:0] a, logic u);
      logic ok;
      if (!e[31]) return 1;
      case (a)
         2'd0: ok = e[30];
         2'd1: ok = e[29];
         2'd2: ok = e[28];
         default: ok = 1'b0;
      endcase
      if (!ok || (u && e[27])) return 2;
      return 0;
   endfunction

   function automatic string tag_of(logic [31:0] e, logic [1:0] a, logic u);
      int f = exp_fault(e, a, u);
      if (f == 1) return "R5";
      if (f == 2) begin
         if (u && e[27] && a != 2'd3 && e[30 - a]) return "R7";
         return "R6";
      end
      if (!u && e[27]) return "R7";
      if (e[26:20] != 7'h0) return "R4";
      return "R8";
   endfunction

   task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   // Compare against the reference every cycle, away from the active edge
   always @(negedge clk) begin
      int    f;
      string t;
      check(req_ready == (m_phase == 0), rst_n ? "R1" : "R10", "req_ready",
            {31'h0, req_ready}, {31'h0, m_phase == 0});
      check(mem_req_valid == (m_phase == 1), rst_n ? "R2" : "R10", "mem_req_valid",
            {31'h0, mem_req_valid}, {31'h0, m_phase == 1});
      if (m_phase == 1)
         check(mem_req_addr == m_addr, "R2", "mem_req_addr", mem_req_addr, m_addr);
      check(rsp_valid == (m_phase == 3), rst_n ? "R3" : "R10", "rsp_valid",
            {31'h0, rsp_valid}, {31'h0, m_phase == 3});
      if (m_phase == 3) begin
         f = exp_fault(m_pte, m_acc, m_user);
         t = tag_of(m_pte, m_acc, m_user);
         check(rsp_fault == f[1:0], t, "rsp_fault", {30'h0, rsp_fault}, f);
         if (f == 1) begin
            check(rsp_perm == 3'b000, "R5", "rsp_perm", {29'h0, rsp_perm}, 0);
            check(rsp_ppn == 20'h0, "R5", "rsp_ppn", {12'h0, rsp_ppn}, 0);
            check(rsp_paddr == 32'h0, "R5", "rsp_paddr", rsp_paddr, 0);
         end else if (f == 2) begin
            check(rsp_perm == m_pte[30:28], "R9", "rsp_perm", {29'h0, rsp_perm}, {29'h0, m_pte[30:28]});
            check(rsp_ppn == 20'h0, "R9", "rsp_ppn", {12'h0, rsp_ppn}, 0);
            check(rsp_paddr == 32'h0, "R9", "rsp_paddr", rsp_paddr, 0);
         end else begin
            check(rsp_perm == m_pte[30:28], t, "rsp_perm", {29'h0, rsp_perm}, {29'h0, m_pte[30:28]});
            check(rsp_ppn == m_pte[19:0], t, "rsp_ppn", {12'h0, rsp_ppn}, {12'h0, m_pte[19:0]});
            check(rsp_paddr == {m_pte[19:0], m_off}, t, "rsp_paddr", rsp_paddr, {m_pte[19:0], m_off});
         end
      end
   end

   function automatic logic [31:0] mk(bit v, bit r, bit w, bit x, bit k, logic [19:0] p);
      return {v, r, w, x, k, 7'h0, p};
   endfunction

   task automatic walk(logic [31:0] base, logic [31:0] va, logic [1:0] acc, bit user,
                       logic [31:0] pte, int latency, bit poke);
      pt_mem[base + {10'h0, va[31:12], 2'b00}] = pte;
      lat = latency;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      ptbr      = base;
      req_vaddr = va;
      req_acc   = acc;
      req_user  = user;
      req_valid = 1'b1;
      @(negedge clk);
      if (poke) begin
         // R1: busy-time request changes must not disturb this walk
         req_vaddr = ~va;
         ptbr      = base ^ 32'h00F0_0000;
         req_acc   = ~acc;
         req_user  = ~user;
      end else begin
         req_valid = 1'b0;
      end
      while (!rsp_valid) @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   // Watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);   // R10 checked while held in reset
      rst_n = 1'b1;
      // R8 load permitted, kernel
      walk(32'h0040_0000, 32'h1234_5678, 2'd0, 1'b0, mk(1,1,0,0,0,20'hABCDE), 1, 0);
      // R6 store on read-only page
      walk(32'h0040_0000, 32'h2000_0ABC, 2'd1, 1'b0, mk(1,1,0,0,0,20'h00111), 2, 0);
      // R8 store permitted, user
      walk(32'h0080_0000, 32'h3456_7FFF, 2'd1, 1'b1, mk(1,1,1,0,0,20'h55555), 3, 0);
      // R8 fetch permitted
      walk(32'h0080_0000, 32'h0000_1000, 2'd2, 1'b1, mk(1,0,0,1,0,20'h0F0F0), 1, 0);
      // R6 fetch without execute
      walk(32'h0080_0000, 32'h0000_2004, 2'd2, 1'b0, mk(1,1,1,0,0,20'h12345), 1, 0);
      // R5 absent mapping with every right
      walk(32'h0040_0000, 32'h7777_7123, 2'd0, 1'b0, mk(0,1,1,1,0,20'hFFFFF), 4, 0);
      // R7 user touches kernel-only page
      walk(32'h0040_0000, 32'h4000_0010, 2'd0, 1'b1, mk(1,1,1,1,1,20'h2468A), 1, 0);
      // R7 kernel touches kernel-only page
      walk(32'h0040_0000, 32'h4000_1010, 2'd0, 1'b0, mk(1,1,1,1,1,20'h13579), 2, 0);
      // R6 reserved access type
      walk(32'h0040_0000, 32'h5000_0000, 2'd3, 1'b0, mk(1,1,1,1,0,20'h00001), 1, 0);
      // R4 filler bits set, R1 busy-time poking, long memory latency
      walk(32'h0100_0000, 32'h6ABC_D321, 2'd0, 1'b0, mk(1,1,0,0,0,20'hBEEF0) | 32'h07F0_0000, 6, 1);
      // R2 highest page number
      walk(32'h1000_0000, 32'hFFFF_FFFF, 2'd0, 1'b0, mk(1,1,0,0,0,20'h80001), 1, 0);
      // R5 page fault wins over every rights problem
      walk(32'h1000_0000, 32'h8000_0000, 2'd3, 1'b1, mk(0,0,0,0,1,20'h00002), 2, 1);
      repeat (4) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule